// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block produces the clock sent to an SD card from a fixed base clock through an 8-bit integer divider. Software or a host engine supplies the wanted card frequency in kHz. A sequential search picks the divisor so that the delivered rate never exceeds the request. On top of that search sit three policies:

- A slow-mode multiplier that a platform can ask for.
- A forced low rate of about 1 MHz that starts at card power-on and lasts until the first bulk transfer ends without error.
- Gating, which stops the card clock while the bus is idle unless idle clocking is allowed.

The block runs on `clk` at twice the nominal base rate. One base period therefore spans two `clk` cycles, and the card clock can keep a 50 % duty cycle for every divisor, including zero. The card clock is a registered level. Gating, ungating and divisor reloads happen only at the end of a low phase, so the card never sees a shortened pulse. The chosen divisor and the resulting rate in kHz are reported for monitoring.

Top module: `sd_clkdiv`

## Requirements
- R1: With no power-up phase and no slow request, `div_o` settles to the smallest d in 0..255 for which BASE_KHZ <= `freq_khz` * (d+1), with BASE_KHZ = 50000. If no d meets this, `div_o` is 255.
- R2: `rate_khz` settles to floor(50000 / (`div_o` + 1)).
- R3: While running, `card_clk` is high for `div_o`+1 `clk` cycles and then low for `div_o`+1 cycles. Each period starts with the high phase.
- R4: With `slow_req` = 1 and no power-up phase, `div_o` = min(8 * d, 255), where d is the R1 result.
- R5: A `pwr_on` pulse starts the power-up phase. In that phase `div_o` = 50 (50000/1000), whatever `freq_khz` and `slow_req` are. The phase ends on an `xfer_ok` pulse. When both pulses arrive in the same cycle, `pwr_on` wins.
- R6: With `idle_clk_ok` = 0 and no power-up phase, `card_clk` toggles only while `busy` = 1 and `freq_khz` is nonzero. Otherwise it stays low.
- R7: With `idle_clk_ok` = 1, `card_clk` keeps toggling while `busy` = 0. With `freq_khz` = 0 it runs at divisor 255.
- R8: During the power-up phase, `card_clk` toggles even with `busy` = 0 and `idle_clk_ok` = 0.
- R9: Every high pulse of `card_clk` lasts exactly the applied divisor + 1 cycles. The clock stops only after a complete low phase.
- R10: A new divisor takes effect only at the start of a new period. Every observed period is whole: its high and low phases have equal length and belong to either the old divisor or the new one.
- R11: During and right after reset, `card_clk` = 0, `div_o` = 255 and `rate_khz` = 195.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the base rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_khz | input | 16 | Requested card frequency in kHz, 0 = stop |
| slow_req | input | 1 | Platform request for slow-mode scaling |
| pwr_on | input | 1 | One-cycle pulse: card power just applied |
| xfer_ok | input | 1 | One-cycle pulse: bulk transfer finished without error |
| idle_clk_ok | input | 1 | Allow the card clock to run while idle |
| busy | input | 1 | A request is in progress on the bus |
| card_clk | output | 1 | Gated, divided card clock |
| div_o | output | 8 | Divisor currently requested of the generator |
| rate_khz | output | 16 | Rate in kHz that `div_o` yields |

## Verification
Two events can land on the same clock edge: the power-on pulse, which opens the slow phase, and the transfer-success pulse, which closes it. The bench drives both on one edge. It then checks that `div_o` still shows the power-up divisor and that the clock keeps running while idle. A later lone success pulse must bring back the searched divisor. A second overlap is a frequency change arriving while the card clock is running: the bench measures successive pulses across the switch and accepts only whole periods of the old or the new length.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef enum logic {
      SR_IDLE = 1'b0,
      SR_SCAN = 1'b1
   } sdclk_scan_e;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } sdclk_phase_e;

endpackage

// File: rtl/sdclk_search.sv
module sdclk_search
   import sdclk_pkg::*;
#(
   parameter int BASE_KHZ = 50000,
   parameter int FREQ_W   = 16,
   parameter int DIV_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [FREQ_W-1:0] freq,
   output logic [DIV_W-1:0]  div_q
);
   localparam int PROD_W = FREQ_W + DIV_W + 1;
   localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

   sdclk_scan_e       st_q;
   logic [DIV_W-1:0]  cand_q;
   logic [PROD_W-1:0] prod;
   logic              hit;

   assign prod = PROD_W'(freq) * (PROD_W'(cand_q) + PROD_W'(1));
   assign hit  = (PROD_W'(BASE_KHZ) <= prod);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SR_IDLE;
         cand_q <= '0;
         div_q  <= DIV_MAX;
      end else if (start) begin
         st_q   <= SR_SCAN;
         cand_q <= '0;
      end else if (st_q == SR_SCAN) begin
         if (hit || cand_q == DIV_MAX) begin
            div_q <= cand_q;
            st_q  <= SR_IDLE;
         end else begin
            cand_q <= cand_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdclk_rate.sv
module sdclk_rate #(
   parameter int BASE_KHZ = 50000,
   parameter int DIV_W    = 8,
   parameter int RATE_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_in,
   output logic [RATE_W-1:0] rate_q
);
   localparam int REM_W = DIV_W + 2;
   localparam int CNT_W = $clog2(RATE_W + 1);
   localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
   localparam int RESET_RATE = BASE_KHZ / (2 ** DIV_W);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [RATE_W-1:0] dvd_q;
   logic [RATE_W-1:0] quo_q;
   logic [REM_W-1:0]  rem_q;
   logic [DIV_W:0]    dsr_q;
   logic [DIV_W-1:0]  last_q;
   logic [REM_W-1:0]  rem_sh;
   logic              ge;

   assign rem_sh = {rem_q[REM_W-2:0], dvd_q[RATE_W-1]};
   assign ge     = (rem_sh >= REM_W'(dsr_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         dvd_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         dsr_q  <= '0;
         last_q <= DIV_MAX;
         rate_q <= RATE_W'(RESET_RATE);
      end else if (!busy_q) begin
         if (div_in != last_q) begin
            last_q <= div_in;
            dsr_q  <= {1'b0, div_in} + 1'b1;
            dvd_q  <= RATE_W'(BASE_KHZ);
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= CNT_W'(RATE_W);
            busy_q <= 1'b1;
         end
      end else begin
         rem_q <= ge ? (rem_sh - REM_W'(dsr_q)) : rem_sh;
         dvd_q <= {dvd_q[RATE_W-2:0], 1'b0};
         quo_q <= {quo_q[RATE_W-2:0], ge};
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            rate_q <= {quo_q[RATE_W-2:0], ge};
         end
      end
   end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             want,
   input  logic [DIV_W-1:0] nxt_div,
   output logic             card_clk,
   output logic             run_o,
   output logic [DIV_W-1:0] cur_div_o
);
   sdclk_phase_e     ph_q;
   logic             run_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_LOW;
         run_q <= 1'b0;
         cnt_q <= '0;
         cur_q <= '0;
      end else if (!run_q) begin
         if (want) begin
            run_q <= 1'b1;
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
            cur_q <= nxt_div;
         end
      end else if (cnt_q == cur_q) begin
         cnt_q <= '0;
         if (ph_q == PH_HIGH) begin
            ph_q <= PH_LOW;
         end else if (want) begin
            ph_q  <= PH_HIGH;
            cur_q <= nxt_div;
         end else begin
            run_q <= 1'b0;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign card_clk  = (ph_q == PH_HIGH);
   assign run_o     = run_q;
   assign cur_div_o = cur_q;

endmodule

// File: rtl/sd_clkdiv.sv
module sd_clkdiv
   import sdclk_pkg::*;
#(
   parameter int BASE_KHZ   = 50000,
   parameter int PP_KHZ     = 1000,
   parameter int SLOW_RATIO = 8,
   parameter int FREQ_W     = 16,
   parameter int DIV_W      = 8,
   parameter int RATE_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq_khz,
   input  logic              slow_req,
   input  logic              pwr_on,
   input  logic              xfer_ok,
   input  logic              idle_clk_ok,
   input  logic              busy,
   output logic              card_clk,
   output logic [DIV_W-1:0]  div_o,
   output logic [RATE_W-1:0] rate_khz
);
   localparam int DIV_MAX_I = (2 ** DIV_W) - 1;
   localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
   localparam int PD_RAW   = BASE_KHZ / PP_KHZ;
   localparam int POST_DIV = (PD_RAW > DIV_MAX_I) ? DIV_MAX_I : PD_RAW;
   localparam int SH       = $clog2(SLOW_RATIO);
   localparam int SC_W     = DIV_W + SH + 1;

   generate
      if (SLOW_RATIO < 1) begin : g_bad_ratio
         $error("SLOW_RATIO must be at least 1");
      end
      if (PP_KHZ < 1) begin : g_bad_pp
         $error("PP_KHZ must be at least 1");
      end
      if (BASE_KHZ >= (2 ** RATE_W)) begin : g_bad_rate_w
         $error("RATE_W too narrow for BASE_KHZ");
      end
      if (DIV_W < 2) begin : g_bad_div_w
         $error("DIV_W must be at least 2");
      end
   endgenerate

   logic              boot_q;
   logic [FREQ_W-1:0] freq_q;
   logic              srch_start;
   logic [DIV_W-1:0]  srch_div;
   logic              pp_q;
   logic [SC_W-1:0]   scaled_w;
   logic [DIV_W-1:0]  scaled;
   logic [DIV_W-1:0]  eff_div;
   logic              want;
   logic              want_q;
   logic              gen_run;
   logic [DIV_W-1:0]  gen_div;
   logic [DIV_W-1:0]  post_div_c;

   assign post_div_c = DIV_W'(POST_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q <= 1'b1;
         freq_q <= '0;
      end else begin
         boot_q <= 1'b0;
         freq_q <= freq_khz;
      end
   end

   assign srch_start = boot_q | (freq_khz != freq_q);

   sdclk_search #(
      .BASE_KHZ(BASE_KHZ),
      .FREQ_W  (FREQ_W),
      .DIV_W   (DIV_W)
   ) u_search (
      .clk  (clk),
      .rst_n(rst_n),
      .start(srch_start),
      .freq (freq_khz),
      .div_q(srch_div)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp_q <= 1'b0;
      end else if (pwr_on) begin
         pp_q <= 1'b1;
      end else if (xfer_ok) begin
         pp_q <= 1'b0;
      end
   end

   generate
      if ((SLOW_RATIO & (SLOW_RATIO - 1)) == 0) begin : g_scale_shift
         assign scaled_w = SC_W'(srch_div) << SH;
      end else begin : g_scale_mul
         assign scaled_w = SC_W'(srch_div) * SC_W'(SLOW_RATIO);
      end
   endgenerate

   assign scaled = (scaled_w > SC_W'(DIV_MAX_I)) ? DIV_MAX : scaled_w[DIV_W-1:0];

   always_comb begin
      if (pp_q) begin
         eff_div = post_div_c;
      end else if (slow_req) begin
         eff_div = scaled;
      end else begin
         eff_div = srch_div;
      end
   end

   assign want = pp_q | idle_clk_ok | (busy & (freq_khz != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_o  <= DIV_MAX;
         want_q <= 1'b0;
      end else begin
         div_o  <= eff_div;
         want_q <= want;
      end
   end

   sdclk_gen #(
      .DIV_W(DIV_W)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want_q),
      .nxt_div  (div_o),
      .card_clk (card_clk),
      .run_o    (gen_run),
      .cur_div_o(gen_div)
   );

   sdclk_rate #(
      .BASE_KHZ(BASE_KHZ),
      .DIV_W   (DIV_W),
      .RATE_W  (RATE_W)
   ) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .div_in(div_o),
      .rate_q(rate_khz)
   );

endmodule

// File: rtl/sd_clkdiv_chk.sv
module sd_clkdiv_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             card_clk,
   input logic             pwr_on,
   input logic             xfer_ok,
   input logic             pp_q,
   input logic [DIV_W-1:0] div_o,
   input logic [DIV_W-1:0] post_div_c,
   input logic             gen_run,
   input logic [DIV_W-1:0] gen_div
);
   logic [DIV_W:0] hi_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len_q <= '0;
      end else if (card_clk) begin
         hi_len_q <= hi_len_q + 1'b1;
      end else begin
         hi_len_q <= '0;
      end
   end

   // R9
   high_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_clk) |-> (hi_len_q == ({1'b0, gen_div} + 1'b1)));

   // R9
   stop_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gen_run) |-> !$past(card_clk));

   // R10
   div_reload_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gen_div) |-> card_clk);

   // R5
   power_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_on |=> ##1 (div_o == post_div_c));

   // R5
   power_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && !pwr_on) |=> !pp_q);

endmodule

bind sd_clkdiv sd_clkdiv_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .card_clk  (card_clk),
   .pwr_on    (pwr_on),
   .xfer_ok   (xfer_ok),
   .pp_q      (pp_q),
   .div_o     (div_o),
   .post_div_c(post_div_c),
   .gen_run   (gen_run),
   .gen_div   (gen_div)
);

// File: tb/tb_sd_clkdiv.sv
`timescale 1ns/1ps
module tb_sd_clkdiv;
   localparam int BASE = 50000;
   localparam int SETTLE = 400;
   localparam int WD_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] freq_khz = '0;
   logic        slow_req = 1'b0;
   logic        pwr_on = 1'b0;
   logic        xfer_ok = 1'b0;
   logic        idle_clk_ok = 1'b0;
   logic        busy = 1'b0;
   logic        card_clk;
   logic [7:0]  div_o;
   logic [15:0] rate_khz;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sd_clkdiv dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .freq_khz   (freq_khz),
      .slow_req   (slow_req),
      .pwr_on     (pwr_on),
      .xfer_ok    (xfer_ok),
      .idle_clk_ok(idle_clk_ok),
      .busy       (busy),
      .card_clk   (card_clk),
      .div_o      (div_o),
      .rate_khz   (rate_khz)
   );

   function automatic int ref_div(input int f);
      for (int d = 0; d < 256; d++) begin
         if (BASE <= f * (d + 1)) return d;
      end
      return 255;
   endfunction

   function automatic int ref_rate(input int d);
      return BASE / (d + 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(output int hi, output int lo, output bit ok);
      int t;
      hi = 0; lo = 0; ok = 1'b0; t = 0;
      while (card_clk !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
      while (card_clk !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
      while (card_clk === 1'b1 && t < 3000) begin hi++; @(negedge clk); t++; end
      while (card_clk === 1'b0 && t < 3000) begin lo++; @(negedge clk); t++; end
      ok = (t < 3000);
   endtask

   task automatic count_high(input int n, output int highs);
      highs = 0;
      repeat (n) begin
         @(negedge clk);
         if (card_clk === 1'b1) highs++;
      end
   endtask

   task automatic pulse(input bit do_pwr, input bit do_ok);
      @(negedge clk);
      pwr_on = do_pwr;
      xfer_ok = do_ok;
      @(negedge clk);
      pwr_on = 1'b0;
      xfer_ok = 1'b0;
   endtask

   task automatic t_reset;
      check(card_clk === 1'b0, "R11 card_clk in reset", int'(card_clk), 0);
      check(div_o === 8'd255, "R11 div_o in reset", int'(div_o), 255);
      check(rate_khz === 16'd195, "R11 rate in reset", int'(rate_khz), 195);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(card_clk === 1'b0, "R11 card_clk after reset", int'(card_clk), 0);
   endtask

   task automatic t_search(input int f);
      int ed;
      @(negedge clk);
      freq_khz = 16'(f);
      idle_wait(SETTLE);
      ed = ref_div(f);
      check(int'(div_o) == ed, $sformatf("R1 divisor for %0d kHz", f), int'(div_o), ed);
      check(int'(rate_khz) == ref_rate(ed), $sformatf("R2 rate for %0d kHz", f),
            int'(rate_khz), ref_rate(ed));
   endtask

   task automatic t_period(input int f);
      int hi, lo, ed, hs;
      bit ok;
      @(negedge clk);
      freq_khz = 16'(f);
      busy = 1'b1;
      idle_wait(SETTLE);
      ed = ref_div(f);
      measure(hi, lo, ok);
      check(ok && hi == ed + 1, "R3 high phase", hi, ed + 1);
      check(ok && lo == ed + 1, "R3 low phase", lo, ed + 1);
      @(negedge clk);
      busy = 1'b0;
      idle_wait(2 * (ed + 1) + 8);
      count_high(600, hs);
      check(hs == 0, "R6 clock gated when idle", hs, 0);
   endtask

   task automatic t_slow;
      int ed;
      @(negedge clk);
      freq_khz = 16'd25000;
      slow_req = 1'b1;
      idle_wait(SETTLE);
      ed = ref_div(25000) * 8;
      check(int'(div_o) == ed, "R4 slow scaling", int'(div_o), ed);
      check(int'(rate_khz) == ref_rate(ed), "R4 slow rate", int'(rate_khz), ref_rate(ed));
      @(negedge clk);
      freq_khz = 16'd400;
      idle_wait(SETTLE);
      check(int'(div_o) == 255, "R4 slow clamp", int'(div_o), 255);
      @(negedge clk);
      slow_req = 1'b0;
      idle_wait(4);
   endtask

   task automatic t_zero_freq;
      int hs;
      @(negedge clk);
      freq_khz = 16'd0;
      busy = 1'b1;
      idle_wait(SETTLE);
      count_high(600, hs);
      check(hs == 0, "R6 zero freq stops clock", hs, 0);
      @(negedge clk);
      busy = 1'b0;
   endtask

   task automatic t_idle_ok;
      int hi, lo;
      bit ok;
      @(negedge clk);
      freq_khz = 16'd0;
      idle_clk_ok = 1'b1;
      idle_wait(SETTLE);
      measure(hi, lo, ok);
      check(ok && hi == 256 && lo == 256, "R7 idle clock at zero freq", hi, 256);
      @(negedge clk);
      freq_khz = 16'd25000;
      idle_wait(SETTLE + 600);
      measure(hi, lo, ok);
      check(ok && hi == 2 && lo == 2, "R7 idle clock at 25 MHz", hi, 2);
      @(negedge clk);
      idle_clk_ok = 1'b0;
      idle_wait(20);
   endtask

   task automatic t_power;
      int hi, lo, ed;
      bit ok;
      @(negedge clk);
      freq_khz = 16'd25000;
      slow_req = 1'b1;
      busy = 1'b0;
      idle_wait(SETTLE);
      pulse(1'b1, 1'b0);
      idle_wait(SETTLE);
      check(int'(div_o) == 50, "R5 power-up divisor", int'(div_o), 50);
      check(int'(rate_khz) == 980, "R5 power-up rate", int'(rate_khz), 980);
      measure(hi, lo, ok);
      check(ok && hi == 51 && lo == 51, "R8 clock runs idle in power-up", hi, 51);
      pulse(1'b1, 1'b1);
      idle_wait(20);
      check(int'(div_o) == 50, "R5 power-on wins over transfer ok", int'(div_o), 50);
      measure(hi, lo, ok);
      check(ok && hi == 51, "R8 still running after coincident pulses", hi, 51);
      pulse(1'b0, 1'b1);
      idle_wait(20);
      ed = ref_div(25000) * 8;
      check(int'(div_o) == ed, "R5 transfer ok ends power-up", int'(div_o), ed);
      @(negedge clk);
      slow_req = 1'b0;
      idle_wait(SETTLE);
   endtask

   task automatic t_switch;
      int hi, lo, big, good, iter;
      bit ok;
      @(negedge clk);
      freq_khz = 16'd25000;
      busy = 1'b1;
      idle_wait(SETTLE);
      @(negedge clk);
      freq_khz = 16'd400;
      big = 0; good = 1; iter = 0;
      while (big < 2 && iter < 100) begin
         measure(hi, lo, ok);
         if (!ok || hi != lo || (hi != 2 && hi != 125)) good = 0;
         if (hi == 125) big++;
         iter++;
      end
      check(good == 1 && big == 2, "R10 whole periods across divisor change", hi, 125);
      @(negedge clk);
      busy = 1'b0;
      idle_wait(300);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle_wait(3);
      t_reset();
      t_search(16666);
      t_search(25000);
      t_search(400);
      t_search(100);
      t_search(50000);
      t_search(60000);
      t_period(16666);
      t_period(400);
      t_slow();
      t_zero_freq();
      t_idle_ok();
      t_power();
      t_switch();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule